// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses register windows. Software addresses 32 architectural registers with a 5-bit number. Behind them sits a larger physical pool. A pointer to the current window selects which part of the pool the windowed groups reach. Two read ports and one write port share that mapping.

A save command moves the window forward. The caller's outgoing registers then become the callee's incoming registers, and the callee gets fresh locals and outgoing registers. A restore command moves the window back. The block counts how many windows are resident. When a move would overwrite live data, or would return into a window that is no longer held, the pointer stays where it is and a one-cycle trap request is raised instead.

Spilling windows to memory and filling them back is left to trap handlers outside the block. Two clean-up commands let such a handler tell the block that it has moved one window out of the pool or back into it.

Top module: `winreg_file`

## Requirements
- R1: Architectural numbers map in groups of eight: 0-7 global, 8-15 outgoing, 16-23 local, 24-31 incoming. Globals 1-7 reach the same storage in every window, and a save or restore leaves their contents unchanged.
- R2: A read of register 0 returns zero, and a write to register 0 leaves every readable register unchanged.
- R3: After a save, incoming registers 24+k of the new window show what outgoing register 8+k of the old window held. This also holds across the wrap from window 7 to window 0.
- R4: The locals and outgoing registers of a new window use storage that no window between it and the oldest resident window uses. After writes in the callee and a restore, the caller's locals and outgoing registers read back unchanged.
- R5: A save with fewer than NWIN-1 resident windows adds one to the window pointer, modulo NWIN, and one to the resident count. A restore with more than one resident window subtracts one from both.
- R6: A save with NWIN-1 resident windows asserts the overflow trap for exactly one cycle, in the cycle after the command, and leaves the pointer and the count unchanged.
- R7: A restore with one resident window asserts the underflow trap for exactly one cycle, in the cycle after the command, and leaves the pointer and the count unchanged.
- R8: The spill command subtracts one from the resident count, and the fill command adds one. A spill at a count of 1 and a fill at a count of NWIN-1 have no effect. Neither command moves the pointer.
- R9: Read data appears one cycle after the address is presented. A write commits at the clock edge and uses the window in force before any shift at that edge. A read at the same edge returns the earlier contents.
- R10: Reset sets the pointer to 0 and the resident count to 1, and it drops both trap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Architectural number for read port A |
| rd_addr_b | input | 5 | Architectural number for read port B |
| rd_data_a | output | 32 | Read data A, one cycle later |
| rd_data_b | output | 32 | Read data B, one cycle later |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | 32 | Write data |
| save_i | input | 1 | Move the window forward |
| restore_i | input | 1 | Move the window back |
| spill_i | input | 1 | Handler moved the oldest window out |
| fill_i | input | 1 | Handler moved a window back in |
| cwp_o | output | 3 | Current window pointer |
| resident_o | output | 3 | Number of resident windows |
| ovf_trap_o | output | 1 | Overflow trap strobe |
| unf_trap_o | output | 1 | Underflow trap strobe |

## Verification
The assertions assume that at most one of save, restore, spill and fill is high in any cycle. The assertion on the control inputs states this assumption. The bench issues each command from its own task and clears it one cycle later, so no two commands ever overlap. The bench holds every input low during reset. It never reads an outgoing register of a window it has not yet written.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  // Group code taken from the top two bits of an architectural register number
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;
endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int AW   = $clog2(4 * NREG),
  parameter int WPW  = $clog2(NWIN),
  parameter int PW   = $clog2(NREG + NWIN * 2 * NREG)
) (
  input  logic [WPW-1:0] cwp,
  input  logic [AW-1:0]  arch,
  output logic [PW-1:0]  phys
);
  import winreg_pkg::*;

  localparam int OW   = $clog2(NREG);
  localparam int STEP = 2 * NREG;

  grp_e           grp;
  logic [OW-1:0]  off;
  logic [WPW-1:0] prev;

  always_comb begin
    grp  = grp_e'(arch[AW-1:AW-2]);
    off  = arch[OW-1:0];
    prev = cwp - 1'b1;
    unique case (grp)
      GRP_GLB: phys = PW'(int'(off));
      GRP_OUT: phys = PW'(NREG + int'(cwp) * STEP + int'(off));
      GRP_LOC: phys = PW'(NREG + int'(cwp) * STEP + NREG + int'(off));
      default: phys = PW'(NREG + int'(prev) * STEP + int'(off));
    endcase
  end
endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl #(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN),
  parameter int CW   = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           save_i,
  input  logic           restore_i,
  input  logic           spill_i,
  input  logic           fill_i,
  output logic [WPW-1:0] cwp,
  output logic [CW-1:0]  resident,
  output logic           ovf,
  output logic           unf
);
  localparam logic [CW-1:0] MAXRES = CW'(NWIN - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      resident <= ONE;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (save_i) begin
        if (resident == MAXRES) begin
          ovf <= 1'b1;
        end else begin
          cwp      <= cwp + 1'b1;
          resident <= resident + 1'b1;
        end
      end else if (restore_i) begin
        if (resident == ONE) begin
          unf <= 1'b1;
        end else begin
          cwp      <= cwp - 1'b1;
          resident <= resident - 1'b1;
        end
      end else if (spill_i) begin
        if (resident > ONE) resident <= resident - 1'b1;
      end else if (fill_i) begin
        if (resident < MAXRES) resident <= resident + 1'b1;
      end
    end
  end

  // Input assumption: at most one command per cycle
  a_cmd_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_i, restore_i, spill_i, fill_i}));

  a_r5_save_moves: assert property (@(posedge clk) disable iff (rst)
    (save_i && resident != MAXRES) |=>
      (cwp == WPW'($past(cwp) + 1'b1)) && (resident == CW'($past(resident) + 1'b1)));

  a_r5_restore_moves: assert property (@(posedge clk) disable iff (rst)
    (restore_i && resident != ONE) |=>
      (cwp == WPW'($past(cwp) - 1'b1)) && (resident == CW'($past(resident) - 1'b1)));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (save_i && resident == MAXRES) |=> ovf && $stable(cwp) && $stable(resident));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (restore_i && resident == ONE) |=> unf && $stable(cwp) && $stable(resident));

  a_r8_count_range: assert property (@(posedge clk) disable iff (rst)
    (resident >= ONE) && (resident <= MAXRES));

  a_r8_cleanup_keeps_cwp: assert property (@(posedge clk) disable iff (rst)
    (spill_i || fill_i) |=> $stable(cwp));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int AW   = $clog2(4 * NREG),
  parameter int WPW  = $clog2(NWIN),
  parameter int CW   = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  rd_addr_a,
  input  logic [AW-1:0]  rd_addr_b,
  output logic [DW-1:0]  rd_data_a,
  output logic [DW-1:0]  rd_data_b,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           save_i,
  input  logic           restore_i,
  input  logic           spill_i,
  input  logic           fill_i,
  output logic [WPW-1:0] cwp_o,
  output logic [CW-1:0]  resident_o,
  output logic           ovf_trap_o,
  output logic           unf_trap_o
);
  localparam int PHYS   = NREG + NWIN * 2 * NREG;
  localparam int PW     = $clog2(PHYS);
  localparam int NPORTS = 3;

  logic [WPW-1:0] cwp;
  logic [AW-1:0]  arch_sel [NPORTS];
  logic [PW-1:0]  phys_sel [NPORTS];

  assign arch_sel[0] = rd_addr_a;
  assign arch_sel[1] = rd_addr_b;
  assign arch_sel[2] = wr_addr;

  winreg_ctl #(.NWIN(NWIN), .WPW(WPW), .CW(CW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .save_i    (save_i),
    .restore_i (restore_i),
    .spill_i   (spill_i),
    .fill_i    (fill_i),
    .cwp       (cwp),
    .resident  (resident_o),
    .ovf       (ovf_trap_o),
    .unf       (unf_trap_o)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    winreg_map #(.NWIN(NWIN), .NREG(NREG), .AW(AW), .WPW(WPW), .PW(PW)) u_map (
      .cwp  (cwp),
      .arch (arch_sel[p]),
      .phys (phys_sel[p])
    );
  end

  // Pool storage: one write port, two registered reads (read-first)
  logic [DW-1:0] mem [PHYS];
  logic [DW-1:0] q_a, q_b;
  logic          zero_a, zero_b;
  logic          wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) mem[phys_sel[2]] <= wr_data;
    q_a <= mem[phys_sel[0]];
    q_b <= mem[phys_sel[1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_a <= 1'b1;
      zero_b <= 1'b1;
    end else begin
      zero_a <= (rd_addr_a == '0);
      zero_b <= (rd_addr_b == '0);
    end
  end

  assign rd_data_a = zero_a ? '0 : q_a;
  assign rd_data_b = zero_b ? '0 : q_b;
  assign cwp_o     = cwp;

  a_r2_zero_read_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |=> (rd_data_a == '0));

  a_r2_zero_read_b: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |=> (rd_data_b == '0));
endmodule

// File: tb/winreg_file_bench.sv
`timescale 1ns/100ps
module winreg_file_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;
  logic        save_i = 1'b0, restore_i = 1'b0, spill_i = 1'b0, fill_i = 1'b0;
  logic [2:0]  cwp_o, resident_o;
  logic        ovf_trap_o, unf_trap_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  winreg_file u_winreg_file (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save_i(save_i), .restore_i(restore_i), .spill_i(spill_i), .fill_i(fill_i),
    .cwp_o(cwp_o), .resident_o(resident_o),
    .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
  );

  function automatic logic [31:0] val(int id, int r);
    return 32'h5A00_0000 | 32'(id << 8) | 32'(r);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd2(int a, int b, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    rd_addr_a = 5'(a); rd_addr_b = 5'(b);
    @(negedge clk);
    da = rd_data_a; db = rd_data_b;
  endtask

  // op: 0 save, 1 restore, 2 spill, 3 fill; samples right after the edge
  task automatic cmd(int op);
    @(negedge clk);
    save_i = (op == 0); restore_i = (op == 1); spill_i = (op == 2); fill_i = (op == 3);
    @(negedge clk);
    save_i = 0; restore_i = 0; spill_i = 0; fill_i = 0;
  endtask

  task automatic state(string req, int ecwp, int eres, bit eovf, bit eunf);
    chk(req, 32'(cwp_o), 32'(ecwp));
    chk(req, 32'(resident_o), 32'(eres));
    chk(req, 32'(ovf_trap_o), 32'(eovf));
    chk(req, 32'(unf_trap_o), 32'(eunf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    state("R10 reset", 0, 1, 0, 0);

    // Window 0: fill every register, read all back (R1 R9 R2)
    for (int r = 1; r < 32; r++) wr(r, val(0, r));
    for (int r = 0; r < 32; r++) begin
      rd2(r, 31 - r, a, b);
      chk("R9 readback a", a, (r == 0) ? 32'h0 : val(0, r));
      chk("R9 readback b", b, (r == 31) ? 32'h0 : val(0, 31 - r));
    end

    // Saves up to the resident limit
    for (int L = 1; L <= 6; L++) begin
      cmd(0);
      state("R5 save", L, L + 1, 0, 0);
      for (int o = 0; o < 8; o++) begin
        rd2(24 + o, 1 + (o % 7), a, b);
        chk("R3 ins from outs", a, val(L - 1, 8 + o));
        chk("R1 global shared", b, val(0, 1 + (o % 7)));
      end
      for (int r = 8; r < 24; r++) wr(r, val(L, r));
    end

    // Overflow at the limit
    cmd(0);
    state("R6 overflow strobe", 6, 7, 1, 0);
    @(negedge clk);
    chk("R6 strobe one cycle", 32'(ovf_trap_o), 32'h0);

    // Restores back to window 0
    for (int L = 6; L >= 1; L--) begin
      for (int r = 8; r < 24; r++) begin
        rd2(r, 24 + (r % 8), a, b);
        chk("R4 locals outs kept", a, val(L, r));
        chk("R3 ins kept", b, val(L - 1, 8 + (r % 8)));
      end
      cmd(1);
      state("R5 restore", L - 1, L, 0, 0);
    end
    for (int r = 1; r < 32; r++) begin
      rd2(r, r, a, b);
      chk("R4 base window intact", a, val(0, r));
    end

    // Underflow, clean-up commands
    cmd(1);
    state("R7 underflow strobe", 0, 1, 0, 1);
    @(negedge clk);
    chk("R7 strobe one cycle", 32'(unf_trap_o), 32'h0);
    cmd(2);
    state("R8 spill ignored at 1", 0, 1, 0, 0);
    cmd(3);
    state("R8 fill", 0, 2, 0, 0);
    cmd(1);
    state("R5 restore wrap", 7, 1, 0, 0);
    for (int o = 0; o < 8; o++) begin
      rd2(24 + o, 0, a, b);
      chk("R3 ins across wrap", a, val(6, 8 + o));
    end
    cmd(0);
    state("R5 save wrap", 0, 2, 0, 0);
    for (int r = 8; r < 24; r++) begin
      rd2(r, 0, a, b);
      chk("R4 window 0 untouched", a, val(0, r));
      chk("R2 zero on b", b, 32'h0);
    end
    for (int k = 0; k < 5; k++) cmd(3);
    state("R8 fill to limit", 0, 7, 0, 0);
    cmd(3);
    state("R8 fill ignored at limit", 0, 7, 0, 0);
    cmd(0);
    state("R6 overflow after fills", 0, 7, 1, 0);
    cmd(2);
    state("R8 spill", 0, 6, 0, 0);
    cmd(0);
    state("R5 save after spill", 1, 7, 0, 0);
    for (int o = 0; o < 8; o++) begin
      rd2(24 + o, 16 + o, a, b);
      chk("R3 ins after spill", a, val(0, 8 + o));
      chk("R4 locals window 1", b, val(1, 16 + o));
    end

    // Register 0 write ignored
    wr(0, 32'hFFFF_FFFF);
    rd2(0, 1, a, b);
    chk("R2 r0 reads zero", a, 32'h0);
    chk("R2 r1 unchanged", b, val(0, 1));

    // Read at the same edge as a write returns old data
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'hC0DE_0016; rd_addr_a = 5'd16;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 read-first", rd_data_a, val(1, 16));
    @(negedge clk);
    chk("R9 new data visible", rd_data_a, 32'hC0DE_0016);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule